// File: doc/BRIEF.md
# Two-Press Instruction Loader

This block builds a 16-bit instruction word from an 8-bit input bus that an operator sets by hand, one half per pushbutton press. The first press takes the opcode and the lower field; the second press takes the upper eight bits. After the second half arrives, the block presents the decoded opcode, the two register addresses and the 8-bit immediate to a downstream controller, along with a one-cycle ready strobe.

The button input is assumed already debounced. It passes through a two-flop synchronizer and a rising-edge detector, so one press loads exactly one half no matter how long the button is held. An internal toggle flag records whether the next press is the first half or the second half. The flag is brought out so the operator can see which half the block expects next. Reset is synchronous and active low.

Bit layout of the assembled word: the opcode is word[3:0], the rs1 address is word[6:4], and the immediate is word[15:8]. In register-register form, the rs2 address is word[10:7], so its top three bits come from the second byte. Its low bit is bit 7 of the first byte.

Top module: `instr_loader`

## Requirements
- R1: While `rstN` is low at a clock edge, the outputs `opcode`, `rs1Addr`, `rs2Addr`, `immValue`, `upperPending` and `instrReady` are all zero after that edge.
- R2: A press taken while `upperPending` is 0 loads `opcode` = `dataIn[3:0]` and `rs1Addr` = `dataIn[6:4]`, leaves `immValue` unchanged, and sets `upperPending` to 1.
- R3: A press taken while `upperPending` is 1 loads `immValue` = `dataIn[7:0]`, leaves `opcode` and `rs1Addr` unchanged, and clears `upperPending` to 0.
- R4: After the second press, `rs2Addr` = {second byte [2:0], first byte [7]}. This is word bits [10:7].
- R5: Holding the button for many cycles loads only once. Changes on `dataIn` during the hold, and the release itself, leave every output unchanged.
- R6: `instrReady` is high for exactly one cycle. That cycle is the one that follows the clock edge that latched the second half. `instrReady` never rises after a first-half load.
- R7: A rising `btnIn` takes effect at the third rising clock edge after it is sampled high. Before that edge, the outputs do not change.
- R8: A reset between the two presses clears `upperPending`, so the next press is treated as a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| btnIn | input | 1 | Debounced pushbutton level |
| dataIn | input | 8 | Manual instruction byte |
| opcode | output | 4 | Instruction word bits [3:0] |
| rs1Addr | output | 3 | Instruction word bits [6:4] |
| rs2Addr | output | 4 | Instruction word bits [10:7] |
| immValue | output | 8 | Instruction word bits [15:8] |
| upperPending | output | 1 | 1 when the next press is taken as the upper half |
| instrReady | output | 1 | One-cycle pulse after the upper half is latched |

## Verification
The bench sweeps every first byte and pairs each with a second byte computed from it. This catches:
- a swapped or shifted field, which would show as a wrong `opcode`, `rs1Addr` or `immValue`;
- an rs2 address that is split wrongly across the two bytes, which would show as a wrong `rs2Addr`.

It holds the button for several cycles while `dataIn` changes. A level-triggered loader would overwrite fields or toggle the half flag more than once. It also samples one edge before the expected load, so a design with a shorter synchronizer would update early. A design that pulses `instrReady` on the first half, or for more than one cycle, is caught by sampling the strobe around each load. A reset between the two halves would leave a sticky flag that routes the next byte into the immediate.

// File: rtl/instr_loader_pkg.sv
package instr_loader_pkg;
  localparam int BUS_W   = 8;
  localparam int OPC_W   = 4;
  localparam int LOW_W   = BUS_W - OPC_W;
  localparam int FIELD_W = LOW_W + BUS_W;
  localparam int RS1_W   = 3;
  localparam int RS2_W   = 4;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
  } loadStrobe_t;
endpackage

// File: rtl/instr_loader_ctrl.sv
module instr_loader_ctrl
  import instr_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnIn,
  output loadStrobe_t strobe,
  output logic        upperPending,
  output logic        instrReady
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   btnPrev;
  logic                   btnRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain    <= '0;
      btnPrev      <= 1'b0;
      upperPending <= 1'b0;
      instrReady   <= 1'b0;
    end else begin
      syncChain  <= {syncChain[SYNC_STAGES-2:0], btnIn};
      btnPrev    <= syncChain[SYNC_STAGES-1];
      instrReady <= strobe.loadHigh;
      if (btnRise) upperPending <= ~upperPending;
    end
  end

  always_comb begin
    btnRise         = syncChain[SYNC_STAGES-1] & ~btnPrev;
    strobe.loadLow  = btnRise & ~upperPending;
    strobe.loadHigh = btnRise & upperPending;
  end

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrReady |=> !instrReady);
  // R6
  ready_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLow |=> !instrReady);
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLow |=> upperPending);
  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHigh |=> !upperPending);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadLow || strobe.loadHigh) |=> $stable(upperPending));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLow, strobe.loadHigh}));
endmodule

// File: rtl/instr_loader_dp.sv
module instr_loader_dp
  import instr_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  loadStrobe_t        strobe,
  input  logic [BUS_W-1:0]   dataIn,
  output logic [OPC_W-1:0]   opcode,
  output logic [RS1_W-1:0]   rs1Addr,
  output logic [RS2_W-1:0]   rs2Addr,
  output logic [BUS_W-1:0]   immValue
);
  logic [OPC_W-1:0]   opcodeReg;
  logic [FIELD_W-1:0] fieldReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeReg <= '0;
      fieldReg  <= '0;
    end else begin
      if (strobe.loadLow) begin
        opcodeReg           <= dataIn[OPC_W-1:0];
        fieldReg[LOW_W-1:0] <= dataIn[BUS_W-1:OPC_W];
      end
      if (strobe.loadHigh) fieldReg[FIELD_W-1:LOW_W] <= dataIn;
    end
  end

  always_comb begin
    opcode   = opcodeReg;
    rs1Addr  = fieldReg[RS1_W-1:0];
    rs2Addr  = fieldReg[RS1_W+RS2_W-1:RS1_W];
    immValue = fieldReg[FIELD_W-1:LOW_W];
  end

  // R2
  low_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLow |=> opcode == $past(dataIn[OPC_W-1:0]) && rs1Addr == $past(dataIn[OPC_W+RS1_W-1:OPC_W]));
  // R3
  high_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHigh |=> immValue == $past(dataIn));
  // R5
  low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLow |=> $stable(opcode) && $stable(rs1Addr));
  // R5
  high_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadHigh |=> $stable(immValue));
endmodule

// File: rtl/instr_loader.sv
module instr_loader
  import instr_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnIn,
  input  logic [7:0] dataIn,
  output logic [3:0] opcode,
  output logic [2:0] rs1Addr,
  output logic [3:0] rs2Addr,
  output logic [7:0] immValue,
  output logic       upperPending,
  output logic       instrReady
);
  loadStrobe_t strobe;

  instr_loader_ctrl #(.SYNC_STAGES(2)) ctrl (
    .clk(clk), .rstN(rstN), .btnIn(btnIn), .strobe(strobe),
    .upperPending(upperPending), .instrReady(instrReady)
  );

  instr_loader_dp dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .opcode(opcode), .rs1Addr(rs1Addr), .rs2Addr(rs2Addr), .immValue(immValue)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> opcode == '0 && immValue == '0 && !upperPending && !instrReady);
endmodule

// File: tb/instr_loader_test.sv
`timescale 1ns/100ps
module instr_loader_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       btnIn = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [3:0] opcode;
  logic [2:0] rs1Addr;
  logic [3:0] rs2Addr;
  logic [7:0] immValue;
  logic       upperPending;
  logic       instrReady;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  instr_loader uut (
    .clk(clk), .rstN(rstN), .btnIn(btnIn), .dataIn(dataIn),
    .opcode(opcode), .rs1Addr(rs1Addr), .rs2Addr(rs2Addr), .immValue(immValue),
    .upperPending(upperPending), .instrReady(instrReady)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // raise button, stop just after the third edge (the load edge)
  task automatic pressEdge(input logic [7:0] d);
    @(negedge clk);
    dataIn = d;
    btnIn  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic releaseBtn(input int hold, input logic [7:0] junk);
    @(negedge clk);
    dataIn = junk;
    repeat (hold) @(negedge clk);
    btnIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b2;
    logic [3:0] expOpc;
    logic [2:0] expRs1;
    logic [7:0] prevImm;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1", "opcode", opcode, 0);
    check("R1", "immValue", immValue, 0);
    check("R1", "rs2Addr", rs2Addr, 0);
    check("R1", "upperPending", upperPending, 0);
    check("R1", "instrReady", instrReady, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R7: no change one edge before the load edge
    @(negedge clk);
    dataIn = 8'hA5;
    btnIn  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R7", "opcode early", opcode, 0);
    check("R7", "upperPending early", upperPending, 0);
    @(posedge clk);
    #1;
    check("R7", "opcode at third edge", opcode, 5);
    check("R7", "upperPending at third edge", upperPending, 1);
    releaseBtn(2, 8'h00);

    // R8: reset between halves
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R8", "upperPending after reset", upperPending, 0);
    pressEdge(8'h3C);
    check("R8", "press after reset is first half", opcode, 4'hC);
    check("R8", "upperPending", upperPending, 1);
    check("R8", "immValue untouched", immValue, 0);
    releaseBtn(1, 8'h3C);
    pressEdge(8'h00);
    releaseBtn(1, 8'h00);

    prevImm = 8'h00;
    for (int a = 0; a < 256; a++) begin
      b2 = 8'(a * 37 + 11);
      expOpc = a[3:0];
      expRs1 = a[6:4];
      // first half
      pressEdge(8'(a));
      check("R2", "opcode", opcode, expOpc);
      check("R2", "rs1Addr", rs1Addr, expRs1);
      check("R2", "immValue kept", immValue, prevImm);
      check("R2", "upperPending", upperPending, 1);
      check("R6", "no ready on first half", instrReady, 0);
      // R5: long hold with changing data
      releaseBtn(3 + (a % 5), ~8'(a));
      check("R5", "opcode after hold", opcode, expOpc);
      check("R5", "upperPending after hold", upperPending, 1);
      check("R6", "ready idle", instrReady, 0);
      // second half
      pressEdge(b2);
      check("R3", "immValue", immValue, b2);
      check("R3", "opcode kept", opcode, expOpc);
      check("R3", "rs1Addr kept", rs1Addr, expRs1);
      check("R3", "upperPending", upperPending, 0);
      check("R4", "rs2Addr", rs2Addr, {b2[2:0], a[7]});
      check("R6", "ready pulse", instrReady, 1);
      @(posedge clk);
      #1;
      check("R6", "ready one cycle", instrReady, 0);
      releaseBtn(2, 8'(a + 1));
      check("R5", "immValue after hold", immValue, b2);
      check("R5", "upperPending after hold", upperPending, 0);
      prevImm = b2;
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule